// File: doc/BRIEF.md
# Keyed Two-Ended Entry Stack

This block holds a small table of 16-bit register-remap entries, each found by a 5-bit key in its low bits. The occupied entries always sit together, starting at slot 0. Two command ends act on the table. The top end works on the highest occupied slot. The bottom end works on slot 0 and moves every other entry up or down to make room or close the gap. Software uses this to treat the table as the top of a stack. It can push a caller's entries back in, pop a callee's entries off, and spill whatever is pushed out to memory on its own.

A command is either an immediate pop of N entries or a register-form word. A register-form word of all zeros pops one entry. A nonzero word is split into 16-bit chunks. Each chunk either updates the entry with the same key or pushes a new entry. When the table is full, a push evicts the entry at the opposite end. Popped and evicted entries are packed into an XLEN-wide result, first one in the lowest bits. The block performs one pop or one chunk per clock and pulses done when the result is final. A separate combinational port looks up an entry by key.

Top module: `keytab_stack`

## Requirements
- R1: The table holds DEPTH (16) entries of 16 bits, and an entry's key is bits 4:0. Occupied slots are always 0..count-1, and empty slots hold zero. Given lk_key, lk_hit is 1 and lk_entry is the occupied entry with that key; otherwise lk_hit is 0 and lk_entry is 0.
- R2: A command is taken when cmd_valid and cmd_ready are both high at a rising edge. After that, cmd_ready stays low for k+1 cycles, where k is the number of pops or chunks the command performs. res_done is then high for exactly one cycle, together with cmd_ready. res_data holds its value until the next command is taken.
- R3: An immediate pop (cmd_imm=1) on the top end (cmd_bottom=0) removes the highest occupied entries one at a time. The first entry removed is placed in result bits 15:0 and the next one down in bits 31:16.
- R4: An immediate pop on the bottom end (cmd_bottom=1) removes slot 0 repeatedly, so the remaining entries move down by the number removed. The first entry removed is placed in bits 15:0.
- R5: The pop count N is cmd_opnd[4:0]. With cmd_dst_zero=0, min(N, XLEN/16) entries are removed. With cmd_dst_zero=1, exactly N pops are performed, and only the first XLEN/16 removed entries appear in the result.
- R6: A register-form command (cmd_imm=0) whose operand is all zeros pops exactly one entry. On the top end this is the highest occupied entry; on the bottom end it is slot 0, and the rest move down by one.
- R7: A nonzero register-form operand is handled one 16-bit chunk per cycle, starting with bits 15:0. Handling stops at the first all-zero chunk or after XLEN/16 chunks.
- R8: A chunk whose key equals the key of an occupied entry overwrites that entry in place. The entry count and all other slots stay unchanged.
- R9: An unmatched chunk on the top end is placed just above the highest occupied slot. On the bottom end it is placed in slot 0, and every entry moves up by one.
- R10: When the table is full, an unmatched top push evicts slot 0 and an unmatched bottom push evicts the highest slot. Evicted entries are packed into the result in eviction order, the first in bits 15:0.
- R11: Result bits not filled by a removed or evicted entry read as zero. A pop from an empty table leaves the table unchanged and contributes a zero field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a new command can be taken |
| cmd_bottom | input | 1 | 1 = bottom end, 0 = top end |
| cmd_imm | input | 1 | 1 = immediate pop of N, 0 = register form |
| cmd_opnd | input | XLEN | Pop count in bits 4:0, or packed 16-bit chunks |
| cmd_dst_zero | input | 1 | Destination is x0: pop exactly N |
| res_done | output | 1 | One-cycle pulse when the result is final |
| res_data | output | XLEN | Packed popped or evicted entries |
| lk_key | input | 5 | Lookup key |
| lk_hit | output | 1 | An occupied entry has lk_key |
| lk_entry | output | 16 | Entry found by the lookup, zero on a miss |

## Verification
The assertions check several things on every cycle. Empty slots must be zero and occupied slots nonzero. No key may appear twice. The entry count may move by at most one per clock. An in-place update must leave the count unchanged. The handshake rules must hold: ready drops after a command is taken, done is a single pulse, and the result holds while idle. Only the bench's scenarios can show that entries come out in the right order and land in the right result fields. The same goes for the choice between eviction and append, for the stop at a zero chunk, and for the removal limit that cmd_dst_zero lifts. The bench checks these against a queue model, both at the result and through the lookup port.

// File: rtl/keytab_pkg.sv
package keytab_pkg;
  parameter int unsigned ENT_W = 16;
  parameter int unsigned KEY_W = 5;

  typedef enum logic [2:0] {
    ST_NOP      = 3'd0,
    ST_POP_TOP  = 3'd1,
    ST_POP_BOT  = 3'd2,
    ST_PUT_TOP  = 3'd3,
    ST_PUT_BOT  = 3'd4,
    ST_WRITE    = 3'd5
  } st_op_e;
endpackage

// File: rtl/keytab_store.sv
module keytab_store
  import keytab_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = ENT_W,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_op_e            op,
  input  logic [EW-1:0]     wr_data,
  input  logic [IW-1:0]     wr_idx,
  output logic [DEPTH*EW-1:0] ents,
  output logic [CW-1:0]     cnt,
  output logic [EW-1:0]     out_ent,
  output logic              out_vld
);
  logic [EW-1:0] tbl_q [DEPTH];
  logic [EW-1:0] tbl_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, tbl_en;
  logic [IW-1:0] top_idx, nxt_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign nxt_idx = IW'(cnt_q);
  assign tbl_en  = (op != ST_NOP);

  always_comb begin
    tbl_d   = tbl_q;
    cnt_d   = cnt_q;
    out_ent = '0;
    out_vld = 1'b0;
    case (op)
      ST_POP_TOP: if (!empty) begin
        out_ent          = tbl_q[top_idx];
        out_vld          = 1'b1;
        tbl_d[top_idx]   = '0;
        cnt_d            = cnt_q - CW'(1);
      end
      ST_POP_BOT: if (!empty) begin
        out_ent = tbl_q[0];
        out_vld = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++) tbl_d[i] = tbl_q[i+1];
        tbl_d[DEPTH-1] = '0;
        cnt_d          = cnt_q - CW'(1);
      end
      ST_PUT_TOP: begin
        if (full) begin
          out_ent = tbl_q[0];
          out_vld = 1'b1;
          for (int i = 0; i < DEPTH - 1; i++) tbl_d[i] = tbl_q[i+1];
          tbl_d[DEPTH-1] = wr_data;
        end else begin
          tbl_d[nxt_idx] = wr_data;
          cnt_d          = cnt_q + CW'(1);
        end
      end
      ST_PUT_BOT: begin
        if (full) begin
          out_ent = tbl_q[DEPTH-1];
          out_vld = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
        for (int i = 1; i < DEPTH; i++) tbl_d[i] = tbl_q[i-1];
        tbl_d[0] = wr_data;
      end
      ST_WRITE: tbl_d[wr_idx] = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
      cnt_q <= '0;
    end else if (tbl_en) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= tbl_d[i];
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign ents[g*EW +: EW] = tbl_q[g];
  end
  assign cnt = cnt_q;

  // Occupancy invariant: slots below the count are nonzero, the rest zero.
  logic hole;
  always_comb begin
    hole = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if ((CW'(i) < cnt_q) != (tbl_q[i] != '0)) hole = 1'b1;
  end

  p_occupancy_r1: assert property (@(posedge clk) disable iff (!rst_n) !hole);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q + CW'(1) == $past(cnt_q))));
endmodule

// File: rtl/keytab_match.sv
module keytab_match
  import keytab_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = ENT_W,
  parameter int unsigned KW    = KEY_W,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH*EW-1:0] ents,
  input  logic [CW-1:0]       cnt,
  input  logic [KW-1:0]       key,
  output logic                hit,
  output logic [IW-1:0]       idx,
  output logic [EW-1:0]       ent
);
  logic [DEPTH-1:0] hv;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hv[g] = (CW'(g) < cnt) && (ents[g*EW +: KW] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hv[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
  end

  assign ent = hit ? ents[idx*EW +: EW] : '0;

  // Keys stay unique because pushes update a matching entry in place.
  p_unique_key_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));
endmodule

// File: rtl/keytab_stack.sv
module keytab_stack
  import keytab_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned EW   = ENT_W,
  localparam int unsigned KW   = KEY_W,
  localparam int unsigned NCH  = XLEN / EW,
  localparam int unsigned NW   = $clog2(DEPTH) + 1,
  localparam int unsigned RW   = $clog2(NCH) + 1,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_bottom,
  input  logic            cmd_imm,
  input  logic [XLEN-1:0] cmd_opnd,
  input  logic            cmd_dst_zero,
  output logic            res_done,
  output logic [XLEN-1:0] res_data,
  input  logic [KW-1:0]   lk_key,
  output logic            lk_hit,
  output logic [EW-1:0]   lk_entry
);
  logic            busy_q, busy_d;
  logic            bot_q, bot_d;
  logic            push_q, push_d;
  logic [NW-1:0]   left_q, left_d;
  logic [XLEN-1:0] opnd_q, opnd_d;
  logic [RW-1:0]   ridx_q, ridx_d;
  logic [XLEN-1:0] res_q, res_d;
  logic            done_q, done_d;

  logic            accept, work, ctl_en, pack;
  logic [EW-1:0]   chunk;
  logic [NW-1:0]   n_req;
  st_op_e          st_op;

  logic [DEPTH*EW-1:0] ents;
  logic [CW-1:0]       cnt;
  logic [EW-1:0]       out_ent;
  logic                out_vld;
  logic                m_hit;
  logic [IW-1:0]       m_idx;
  logic [EW-1:0]       m_ent;
  logic [IW-1:0]       lk_idx;

  assign accept = cmd_valid && !busy_q;
  assign chunk  = opnd_q[EW-1:0];
  assign work   = busy_q && (push_q ? (chunk != '0) : (left_q != '0));
  assign ctl_en = accept || busy_q;
  assign pack   = work && (!push_q || out_vld);
  assign n_req  = cmd_opnd[NW-1:0];

  always_comb begin
    st_op = ST_NOP;
    if (work) begin
      if (push_q) st_op = m_hit ? ST_WRITE : (bot_q ? ST_PUT_BOT : ST_PUT_TOP);
      else        st_op = bot_q ? ST_POP_BOT : ST_POP_TOP;
    end
  end

  always_comb begin
    busy_d = busy_q;
    bot_d  = bot_q;
    push_d = push_q;
    left_d = left_q;
    opnd_d = opnd_q;
    ridx_d = ridx_q;
    res_d  = res_q;
    done_d = busy_q && !work;
    if (accept) begin
      busy_d = 1'b1;
      bot_d  = cmd_bottom;
      push_d = !cmd_imm && (cmd_opnd != '0);
      opnd_d = cmd_opnd;
      ridx_d = '0;
      res_d  = '0;
      if (!cmd_imm)          left_d = NW'(1);
      else if (cmd_dst_zero) left_d = n_req;
      else                   left_d = (n_req > NW'(NCH)) ? NW'(NCH) : n_req;
    end else if (busy_q) begin
      if (!work) busy_d = 1'b0;
      if (work && push_q)  opnd_d = opnd_q >> EW;
      if (work && !push_q) left_d = left_q - NW'(1);
      if (pack && (ridx_q < RW'(NCH))) begin
        for (int c = 0; c < NCH; c++)
          if (ridx_q == RW'(c)) res_d[c*EW +: EW] = out_ent;
        ridx_d = ridx_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bot_q  <= 1'b0;
      push_q <= 1'b0;
      left_q <= '0;
      opnd_q <= '0;
      ridx_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (ctl_en) begin
        busy_q <= busy_d;
        bot_q  <= bot_d;
        push_q <= push_d;
        left_q <= left_d;
        opnd_q <= opnd_d;
        ridx_q <= ridx_d;
        res_q  <= res_d;
      end
    end
  end

  keytab_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .op(st_op), .wr_data(chunk), .wr_idx(m_idx),
    .ents(ents), .cnt(cnt), .out_ent(out_ent), .out_vld(out_vld)
  );

  keytab_match #(.DEPTH(DEPTH), .EW(EW), .KW(KW)) u_cmd_match (
    .clk(clk), .rst_n(rst_n), .ents(ents), .cnt(cnt), .key(chunk[KW-1:0]),
    .hit(m_hit), .idx(m_idx), .ent(m_ent)
  );

  keytab_match #(.DEPTH(DEPTH), .EW(EW), .KW(KW)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .ents(ents), .cnt(cnt), .key(lk_key),
    .hit(lk_hit), .idx(lk_idx), .ent(lk_entry)
  );

  assign cmd_ready = !busy_q;
  assign res_done  = done_q;
  assign res_data  = res_q;

  p_take_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> cmd_ready);
  p_res_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(res_data));
  p_update_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_op == ST_WRITE) |=> $stable(cnt));
  p_evict_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_op == ST_PUT_TOP || st_op == ST_PUT_BOT) && out_vld) |-> (cnt == CW'(DEPTH)));
endmodule

// File: tb/keytab_stack_tb.sv
module keytab_stack_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int XLEN  = 32;
  localparam int DEPTH = 16;
  localparam int NCH   = XLEN / 16;

  logic            clk, rst_n;
  logic            cmd_valid, cmd_ready, cmd_bottom, cmd_imm, cmd_dst_zero;
  logic [XLEN-1:0] cmd_opnd, res_data;
  logic            res_done, lk_hit;
  logic [4:0]      lk_key;
  logic [15:0]     lk_entry;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] q[$];

  keytab_stack #(.XLEN(XLEN), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bottom(cmd_bottom), .cmd_imm(cmd_imm), .cmd_opnd(cmd_opnd),
    .cmd_dst_zero(cmd_dst_zero), .res_done(res_done), .res_data(res_data),
    .lk_key(lk_key), .lk_hit(lk_hit), .lk_entry(lk_entry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int key, input int tag);
    return {tag[7:0], 3'b000, key[4:0]};
  endfunction

  // Model: q[0] is slot 0, q[$] is the highest occupied slot.
  task automatic check_lookup(input string rq);
    int bad = 0;
    logic [15:0] a_ent = '0, e_ent_s = '0;
    for (int k = 0; k < 32; k++) begin
      bit e_hit = 0;
      logic [15:0] e_ent = '0;
      foreach (q[i]) if (q[i][4:0] == k[4:0]) begin e_hit = 1; e_ent = q[i]; end
      lk_key = k[4:0];
      #0.25;
      if (lk_hit !== e_hit || lk_entry !== e_ent) begin
        if (bad == 0) begin a_ent = lk_entry; e_ent_s = e_ent; end
        bad++;
      end
    end
    chk(bad == 0, rq, {16'h0, a_ent}, {16'h0, e_ent_s});
  endtask

  task automatic run_cmd(input bit bot, input bit imm, input logic [XLEN-1:0] op,
                         input bit dz, input string rq);
    logic [XLEN-1:0] exp_res = '0;
    int slot = 0;
    int k = 0;
    logic [XLEN-1:0] tmp;
    if (imm || op == '0) begin
      int n;
      if (!imm) n = 1;
      else begin
        n = int'(op[4:0]);
        if (!dz && n > NCH) n = NCH;
      end
      k = n;
      for (int p = 0; p < n; p++) begin
        logic [15:0] v = '0;
        if (q.size() > 0) v = bot ? q.pop_front() : q.pop_back();
        if (slot < NCH) exp_res[16*slot +: 16] = v;
        slot++;
      end
    end else begin
      tmp = op;
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] ch = tmp[15:0];
        int hit_i = -1;
        if (ch == '0) break;
        k++;
        foreach (q[i]) if (q[i][4:0] == ch[4:0]) hit_i = i;
        if (hit_i >= 0) q[hit_i] = ch;
        else if (!bot) begin
          if (q.size() == DEPTH) begin
            exp_res[16*slot +: 16] = q.pop_front();
            slot++;
          end
          q.push_back(ch);
        end else begin
          if (q.size() == DEPTH) begin
            exp_res[16*slot +: 16] = q.pop_back();
            slot++;
          end
          q.push_front(ch);
        end
        tmp = tmp >> 16;
      end
    end
    cmd_valid = 1; cmd_bottom = bot; cmd_imm = imm; cmd_opnd = op; cmd_dst_zero = dz;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready && !res_done, {rq, " R2 busy after take"}, {30'h0, cmd_ready, res_done}, 0);
    for (int c = 0; c < k; c++) begin
      @(negedge clk);
      chk(!cmd_ready && !res_done, {rq, " R2 busy"}, {30'h0, cmd_ready, res_done}, 0);
    end
    @(negedge clk);
    chk(res_done && cmd_ready, {rq, " R2 done"}, {30'h0, cmd_ready, res_done}, 3);
    chk(res_data === exp_res, {rq, " result"}, res_data, exp_res);
    check_lookup({rq, " R1 table via lookup"});
    @(negedge clk);
    chk(!res_done, {rq, " R2 done pulse"}, {31'h0, res_done}, 0);
    chk(res_data === exp_res, {rq, " R2 result held"}, res_data, exp_res);
  endtask

  initial begin
    #(20.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_bottom = 0; cmd_imm = 0; cmd_opnd = '0;
    cmd_dst_zero = 0; lk_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !res_done && res_data == '0, "reset R2", {cmd_ready, res_done, res_data[29:0]}, {2'b10, 30'h0});
    check_lookup("reset R1 empty");

    // R9: top append two chunks, R7 low chunk first
    run_cmd(0, 0, {mk(2, 2), mk(1, 1)}, 0, "R9 R7 top push");
    // R9: bottom insert at slot 0
    run_cmd(1, 0, {16'h0, mk(3, 3)}, 0, "R9 bottom insert");
    // R8: key 1 updated in place
    run_cmd(0, 0, {16'h0, mk(1, 8'hA0)}, 0, "R8 update");
    run_cmd(1, 0, {mk(9, 9), mk(2, 8'hB2)}, 0, "R8 R9 mixed update and insert");
    // R7: low chunk zero stops at once
    run_cmd(0, 0, {mk(5, 5), 16'h0}, 0, "R7 stop at zero chunk");
    // Fill to full and overflow: R10 top eviction
    for (int i = 0; i < 7; i++)
      run_cmd(0, 0, {mk(10 + 2*i + 1, 40 + i), mk(10 + 2*i, 20 + i)}, 0, "R10 fill and top evict");
    // R10 bottom eviction, two in one command
    run_cmd(1, 0, {mk(30, 8'h31), mk(31, 8'h32)}, 0, "R10 bottom evict order");
    // R3 + R5: top pop 3 limited to 2
    run_cmd(0, 1, 32'd3, 0, "R3 R5 top pop limited");
    // R4 + R5: bottom pop 3 with x0 destination
    run_cmd(1, 1, 32'd3, 1, "R4 R5 bottom pop exact");
    // R6: register-zero pops
    run_cmd(0, 0, 32'h0, 0, "R6 top single pop");
    run_cmd(1, 0, 32'h0, 0, "R6 bottom single pop");
    // R11: pop count zero
    run_cmd(0, 1, 32'd0, 0, "R11 zero count");
    run_cmd(1, 1, 32'd1, 0, "R4 bottom pop one R11 upper zero");
    // R5 + R11: drain far past empty
    run_cmd(0, 1, 32'd31, 1, "R5 R11 drain past empty");
    run_cmd(1, 0, 32'h0, 0, "R11 pop empty bottom");
    run_cmd(0, 1, 32'd2, 0, "R11 pop empty top");
    // After empty: push again both ends
    run_cmd(1, 0, {mk(7, 7), mk(6, 6)}, 0, "R9 bottom insert twice");
    run_cmd(0, 1, 32'd2, 0, "R3 top order");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule